// File: doc/BRIEF.md
# Load-Store Lane Alignment Unit

This unit sits between a 32-bit integer datapath and a data memory port that is one word wide. It takes one access request per cycle. A request carries an effective byte address, a width code, a signed or unsigned flag and, for stores, the register value. From these it registers a word-aligned memory address, a per-byte-lane enable mask and store data placed in the active lanes. The memory sees all of these one cycle after the request.

On the load side, the memory returns its word in the cycle after the request. The unit picks the addressed byte or halfword lane from that word and extends it to 32 bits. It does this combinationally, using the request shape it registered on the previous cycle. Lane numbering is little endian: byte offset 0 is data bits [7:0].

A halfword at an odd address, or a word whose two low address bits are not both zero, is reported as misaligned. Such an access never reaches memory.

Top module: `lsu_lane_align`

## Requirements
- R1: A synchronous active-high reset clears mem_addr, mem_be, mem_wdata, mem_we, mem_re and misaligned to zero.
- R2: One cycle after a request, mem_addr equals req_addr with its two low bits cleared. Exactly one of mem_we (store, req_we=1) or mem_re (load) pulses for that cycle unless the access is misaligned. In a cycle after no request, mem_we, mem_re and mem_be are all zero.
- R3: The width code selects the mask: 00 is byte, 01 is halfword, 10 is word, and 11 behaves as word. mem_be is 0001, 0011 or 1111 shifted left by req_addr[1:0]. Bit i enables data bits [8i+7:8i].
- R4: Store data is steered to the lanes. A byte store puts req_wdata[7:0] in all four lanes. A halfword store puts req_wdata[15:0] in both halves. A word store passes all 32 bits unchanged.
- R5: A halfword access with req_addr[0]=1, or a word access with req_addr[1:0]!=0, sets misaligned for that access. It also forces mem_be to 0000 and keeps mem_we and mem_re low.
- R6: A signed byte load (req_unsigned=0) returns lane req_addr[1:0] of mem_rdata, sign-extended to 32 bits.
- R7: An unsigned byte load (req_unsigned=1) returns the same lane, zero-extended.
- R8: A halfword load returns mem_rdata[15:0] when req_addr[1]=0 and mem_rdata[31:16] when req_addr[1]=1. The result is sign-extended when req_unsigned=0 and zero-extended when req_unsigned=1.
- R9: A word load returns mem_rdata unchanged, whatever the value of req_unsigned.
- R10: ld_result follows mem_rdata combinationally, using the shape of the most recent request. It keeps that shape until the next request, and it is zero while that request was misaligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Access request this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Effective byte address |
| req_size | input | 2 | Width code (00 byte, 01 half, 10/11 word) |
| req_unsigned | input | 1 | Zero-extend loaded value |
| req_wdata | input | 32 | Store source register value |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 32 | Word returned by memory |
| misaligned | output | 1 | Most recent access was misaligned |
| ld_result | output | 32 | Extended load value |

## Verification
Every memory-side output (address, enables, write data, strobes and the misaligned flag) is due on the first rising edge after the request edge. The bench therefore drives a request on a falling edge and reads those outputs on the following falling edge. The load result has no register of its own: it is due as soon as mem_rdata changes in the cycle after the request. The bench drives mem_rdata at that falling edge and samples ld_result one nanosecond later. A further case changes mem_rdata with no new request, to show that the registered shape is held.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } acc_size_e;

  // Number of bytes touched by a width code; code 11 acts as a word.
  function automatic int unsigned size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/lsu_store_steer.sv
module lsu_store_steer
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] src,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] lanes,
  output logic              misal
);
  logic [LANES-1:0] base_mask;

  always_comb begin
    case (size)
      SZ_BYTE: begin base_mask = LANES'(1);        misal = 1'b0;      end
      SZ_HALF: begin base_mask = LANES'(3);        misal = off[0];    end
      default: begin base_mask = LANES'(15);       misal = |off[1:0]; end
    endcase
    be = misal ? '0 : (base_mask << off);
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      case (size)
        SZ_BYTE: lanes[8*i +: 8] = src[7:0];
        SZ_HALF: lanes[8*i +: 8] = src[8*(i%2) +: 8];
        default: lanes[8*i +: 8] = src[8*(i%4) +: 8];
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] rdata,
  input  logic [OFF_W-1:0]  off,
  input  logic [1:0]        size,
  input  logic              uns,
  input  logic              misal,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] shifted;
  logic              fill;

  always_comb begin
    shifted = rdata >> {off, 3'b000};
    fill    = 1'b0;
    result  = '0;
    if (!misal) begin
      case (size)
        SZ_BYTE: begin
          fill   = ~uns & shifted[7];
          result = {{(DATA_W-8){fill}}, shifted[7:0]};
        end
        SZ_HALF: begin
          fill   = ~uns & shifted[15];
          result = {{(DATA_W-16){fill}}, shifted[15:0]};
        end
        default: result = shifted;
      endcase
    end
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_unsigned,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              mem_re,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              misaligned,
  output logic [DATA_W-1:0] ld_result
);
  logic [LANES-1:0]  be_c;
  logic [DATA_W-1:0] lanes_c;
  logic              mis_c;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic              uns_q;

  lsu_store_steer #(.DATA_W(DATA_W)) u_steer (
    .off   (req_addr[OFF_W-1:0]),
    .size  (req_size),
    .src   (req_wdata),
    .be    (be_c),
    .lanes (lanes_c),
    .misal (mis_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr   <= '0;
      mem_be     <= '0;
      mem_wdata  <= '0;
      mem_we     <= 1'b0;
      mem_re     <= 1'b0;
      misaligned <= 1'b0;
      off_q      <= '0;
      size_q     <= '0;
      uns_q      <= 1'b0;
    end else begin
      mem_we <= req &  req_we & ~mis_c;
      mem_re <= req & ~req_we & ~mis_c;
      mem_be <= req ? be_c : '0;
      if (req) begin
        mem_addr   <= {req_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
        mem_wdata  <= lanes_c;
        misaligned <= mis_c;
        off_q      <= req_addr[OFF_W-1:0];
        size_q     <= req_size;
        uns_q      <= req_unsigned;
      end
    end
  end

  lsu_load_extract #(.DATA_W(DATA_W)) u_extract (
    .rdata  (mem_rdata),
    .off    (off_q),
    .size   (size_q),
    .uns    (uns_q),
    .misal  (misaligned),
    .result (ld_result)
  );
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic [ADDR_W-1:0] req_addr,
  input logic [1:0]        req_size,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]  mem_be,
  input logic              mem_we,
  input logic              mem_re,
  input logic              misaligned,
  input logic [DATA_W-1:0] ld_result
);
  // R5
  misal_gated_chk: assert property (@(posedge clk) disable iff (rst)
    misaligned |-> (mem_be == '0 && !mem_we && !mem_re));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !req |=> (!mem_we && !mem_re && mem_be == '0));

  // R2
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, mem_re}));

  // R2
  addr_word_chk: assert property (@(posedge clk) disable iff (rst)
    req |=> (mem_addr[ADDR_W-1:2] == $past(req_addr[ADDR_W-1:2]) && mem_addr[1:0] == 2'b00));

  // R3
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (rst)
    (req && req_size == 2'b00) |=> ($countones(mem_be) == 1));

  // R3
  word_all_lanes_chk: assert property (@(posedge clk) disable iff (rst)
    (req && req_size[1] && req_addr[1:0] == 2'b00) |=> (mem_be == '1));

  // R10
  misal_result_zero_chk: assert property (@(posedge clk) disable iff (rst)
    misaligned |-> (ld_result == '0));
endmodule

bind lsu_lane_align lsu_lane_align_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req        (req),
  .req_addr   (req_addr),
  .req_size   (req_size),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .misaligned (misaligned),
  .ld_result  (ld_result)
);

// File: tb/test_lsu_lane_align.sv
module test_lsu_lane_align;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_we = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_unsigned = 1'b0;
  logic [31:0] req_wdata = '0;
  logic [31:0] mem_addr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_we;
  logic        mem_re;
  logic [31:0] mem_rdata = '0;
  logic        misaligned;
  logic [31:0] ld_result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lsu_lane_align i_lsu_lane_align (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_wdata(req_wdata),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
    .misaligned(misaligned), .ld_result(ld_result)
  );

  typedef struct packed {
    logic        we;
    logic [1:0]  off;
    logic [1:0]  size;
    logic        uns;
    logic [31:0] din;
    logic [3:0]  be;
    logic [31:0] exp;
    logic        mis;
  } vec_t;

  localparam logic [31:0] BASE = 32'h2000_0A40;
  localparam logic [31:0] RW   = 32'h8A7B_C6D5;
  localparam logic [31:0] SW   = 32'hCAFE_1942;

  localparam vec_t VECS [0:19] = '{
    '{1'b0, 2'd0, 2'b00, 1'b0, RW, 4'b0001, 32'hFFFF_FFD5, 1'b0},
    '{1'b0, 2'd1, 2'b00, 1'b0, RW, 4'b0010, 32'hFFFF_FFC6, 1'b0},
    '{1'b0, 2'd2, 2'b00, 1'b0, RW, 4'b0100, 32'h0000_007B, 1'b0},
    '{1'b0, 2'd3, 2'b00, 1'b1, RW, 4'b1000, 32'h0000_008A, 1'b0},
    '{1'b0, 2'd1, 2'b00, 1'b1, RW, 4'b0010, 32'h0000_00C6, 1'b0},
    '{1'b0, 2'd0, 2'b01, 1'b0, RW, 4'b0011, 32'hFFFF_C6D5, 1'b0},
    '{1'b0, 2'd2, 2'b01, 1'b0, RW, 4'b1100, 32'hFFFF_8A7B, 1'b0},
    '{1'b0, 2'd2, 2'b01, 1'b1, RW, 4'b1100, 32'h0000_8A7B, 1'b0},
    '{1'b0, 2'd0, 2'b01, 1'b1, RW, 4'b0011, 32'h0000_C6D5, 1'b0},
    '{1'b0, 2'd0, 2'b10, 1'b0, RW, 4'b1111, 32'h8A7B_C6D5, 1'b0},
    '{1'b0, 2'd0, 2'b10, 1'b1, RW, 4'b1111, 32'h8A7B_C6D5, 1'b0},
    '{1'b0, 2'd1, 2'b01, 1'b0, RW, 4'b0000, 32'h0000_0000, 1'b1},
    '{1'b0, 2'd2, 2'b10, 1'b0, RW, 4'b0000, 32'h0000_0000, 1'b1},
    '{1'b1, 2'd0, 2'b00, 1'b0, SW, 4'b0001, 32'h4242_4242, 1'b0},
    '{1'b1, 2'd3, 2'b00, 1'b0, SW, 4'b1000, 32'h4242_4242, 1'b0},
    '{1'b1, 2'd2, 2'b01, 1'b0, SW, 4'b1100, 32'h1942_1942, 1'b0},
    '{1'b1, 2'd0, 2'b10, 1'b0, SW, 4'b1111, 32'hCAFE_1942, 1'b0},
    '{1'b1, 2'd0, 2'b11, 1'b0, SW, 4'b1111, 32'hCAFE_1942, 1'b0},
    '{1'b1, 2'd3, 2'b01, 1'b0, SW, 4'b0000, 32'h0000_0000, 1'b1},
    '{1'b1, 2'd1, 2'b10, 1'b0, SW, 4'b0000, 32'h0000_0000, 1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one request at a falling edge and release it on the next one.
  task automatic issue(input logic we, input logic [31:0] addr, input logic [1:0] sz,
                       input logic uns, input logic [31:0] wd);
    @(negedge clk);
    req = 1'b1; req_we = we; req_addr = addr; req_size = sz;
    req_unsigned = uns; req_wdata = wd;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 mem_addr", mem_addr, 32'h0);
    chk("R1 mem_be", {28'h0, mem_be}, 32'h0);
    chk("R1 mem_wdata", mem_wdata, 32'h0);
    chk("R1 strobes", {30'h0, mem_we, mem_re}, 32'h0);
    chk("R1 misaligned", {31'h0, misaligned}, 32'h0);
    rst = 1'b0;

    for (int k = 0; k < 20; k++) begin
      string tag;
      if (VECS[k].mis)              tag = "R5";
      else if (VECS[k].we)          tag = "R4";
      else if (VECS[k].size == 2'b00) tag = VECS[k].uns ? "R7" : "R6";
      else if (VECS[k].size == 2'b01) tag = "R8";
      else                          tag = "R9";
      issue(VECS[k].we, BASE | {30'h0, VECS[k].off}, VECS[k].size, VECS[k].uns, VECS[k].din);
      if (!VECS[k].we) mem_rdata = VECS[k].din;
      #1;
      chk("R2 mem_addr", mem_addr, BASE);
      chk("R3 mem_be", {28'h0, mem_be}, {28'h0, VECS[k].be});
      chk("R5 misaligned", {31'h0, misaligned}, {31'h0, VECS[k].mis});
      chk("R2 mem_we", {31'h0, mem_we}, {31'h0, VECS[k].we & ~VECS[k].mis});
      chk("R2 mem_re", {31'h0, mem_re}, {31'h0, ~VECS[k].we & ~VECS[k].mis});
      if (VECS[k].we && !VECS[k].mis) chk({tag, " mem_wdata"}, mem_wdata, VECS[k].exp);
      if (!VECS[k].we) chk({tag, " ld_result"}, ld_result, VECS[k].exp);
    end

    // R2: a cycle with no request leaves the port quiet
    @(negedge clk); #1;
    chk("R2 idle strobes", {30'h0, mem_we, mem_re}, 32'h0);
    chk("R2 idle be", {28'h0, mem_be}, 32'h0);

    // R10: shape held, result follows new memory data without a new request
    issue(1'b0, BASE, 2'b00, 1'b0, 32'h0);
    mem_rdata = RW; #1;
    chk("R10 first data", ld_result, 32'hFFFF_FFD5);
    @(negedge clk);
    mem_rdata = 32'h0000_0070; #1;
    chk("R10 held shape", ld_result, 32'h0000_0070);

    // R1: reset wins over a request on the same edge
    @(negedge clk);
    rst = 1'b1; req = 1'b1; req_we = 1'b1; req_addr = BASE; req_size = 2'b10; req_wdata = SW;
    @(negedge clk); #1;
    chk("R1 reset over req we", {31'h0, mem_we}, 32'h0);
    chk("R1 reset over req be", {28'h0, mem_be}, 32'h0);
    chk("R1 reset over req wdata", mem_wdata, 32'h0);
    req = 1'b0; rst = 1'b0;
    @(negedge clk);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule